// File: doc/BRIEF.md
# System Clock Source Switch

This block picks the clock that drives the rest of the chip. It chooses between a primary oscillator input and an internal oscillator block. The internal block has a fast source, which a postscaler divides down, and a separate slow low-power source. Software controls the choice through a byte-wide control and status register on a bus clock. The same register reports whether each internal oscillator is stable, and whether the start-up timer on the primary oscillator has run out.

A separate automatic-switch input, driven by start-up or fail-safe logic, can move the system clock onto the internal block. It does this without touching the software select bit. Every change of source or rate goes through a glitch-free handover. Each source has its own enable synchronizer, clocked on that source's falling edge. Only one new selection is committed at a time, and only after the previous handover has been seen to complete.

The register layout is fixed:

| Bit | Field | Access |
|-----|-------|--------|
| 7 | unused | reads 0 |
| 6:4 | frequency code | read/write |
| 3 | start-up timer expired | read-only |
| 2 | fast source stable | read-only |
| 1 | slow source stable | read-only |
| 0 | source select | read/write |

Top module: `sysclk_switch`

## Requirements
- R1: After reset, `rd_data` reads 8'h60 while `hf_ready` and `lf_ready` are low: frequency code 3'b110 in bits 6:4, and 0 in every other bit. The primary clock then appears on `sys_clk`.
- R2: A write with `wr_en` high loads bit 0 (source select) and bits 6:4 (frequency code) from `wr_data`. Both read back in the same positions. Select 1 routes the internal block to `sys_clk`.
- R3: A write has no effect on bits 7 and 3:1 of `rd_data`. Bit 7 always reads 0, and bits 3:1 show only status.
- R4: While `auto_req` is high, `sys_clk` comes from the internal block at the rate set by the frequency code. This holds even when the select bit is 0, and the select bit keeps its written value.
- R5: The frequency code sets the internal rate. Code 000 gives `lf_clk`. Codes 001, 010, 011, 100, 101 and 110 give `hf_clk` divided by 64, 32, 16, 8, 4 and 2. Code 111 gives `hf_clk` undivided. The divider is a free-running binary counter on `hf_clk`.
- R6: With select 0 and `auto_req` low, `sys_clk` has the period of `pri_clk`.
- R7: Bit 3 is 0 from reset until 1024 rising edges of `pri_clk` have been counted after reset. It then reads 1, and stays 1 until the next reset.
- R8: Bit 2 follows `hf_ready` and bit 1 follows `lf_ready`, through a two-flop synchronizer on `bus_clk`. Each change shows within three `bus_clk` cycles.
- R9: A change of source or rate gates the old clock off on its own falling edge before the new clock is enabled on its own falling edge. At most one source is enabled at any time, and `sys_clk` has no high or low phase shorter than the shortest half period among the sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| pri_clk | input | 1 | Primary oscillator clock |
| hf_clk | input | 1 | Fast internal oscillator clock (postscaler input) |
| lf_clk | input | 1 | Slow low-power internal oscillator clock |
| hf_ready | input | 1 | Fast internal oscillator is stable |
| lf_ready | input | 1 | Slow internal oscillator is stable |
| auto_req | input | 1 | Automatic switch to the internal block |
| wr_en | input | 1 | Register write strobe, sampled on `bus_clk` |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| sys_clk | output | 1 | Selected glitch-free system clock |

## Verification
A wrong tap wiring or frequency decode shows as a `sys_clk` period that differs from the source or divider ratio the code implies. It is visible within one or two periods of the selected clock once the handover has settled. A handover that deadlocks leaves `sys_clk` frozen. A handover that lets two enables overlap produces a runt phase on `sys_clk` at the moment of the switch. A corrupted select bit, frequency code or timer state is visible on the next register read. A timer that counts the wrong number of primary edges moves the setting of bit 3 across the read just before or just after the 1024-edge point.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int FREQ_W    = 3;
  localparam int POST_TAPS = 6;
  // sources: primary, slow, six divided taps, undivided fast
  localparam int NUM_SRC   = POST_TAPS + 3;
  localparam int SRC_PRI   = 0;
  localparam int SRC_LF    = 1;
  localparam int SRC_HF    = NUM_SRC - 1;
  localparam logic [FREQ_W-1:0] FREQ_RESET = 3'b110;
  localparam int REG_W     = 8;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // source slot for a selection: primary, or internal at code+1
  function automatic int src_index(logic internal, logic [FREQ_W-1:0] code);
    if (internal) return int'(code) + 1;
    return SRC_PRI;
  endfunction

  function automatic src_vec_t src_onehot(logic internal, logic [FREQ_W-1:0] code);
    src_vec_t v;
    v = '0;
    v[src_index(internal, code)] = 1'b1;
    return v;
  endfunction

  // counter bit feeding a divided code (codes 1..POST_TAPS): bit b divides by 2^(b+1)
  function automatic int tap_of_code(int code);
    return POST_TAPS - code;
  endfunction
endpackage

// File: rtl/clksel_sync2.sv
`timescale 1ns/1ps
module clksel_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/clksel_postscaler.sv
`timescale 1ns/1ps
module clksel_postscaler #(
  parameter int TAPS = 6
) (
  input  logic            hf_clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] div_clk
);
  logic [TAPS-1:0] cnt_q;

  always_ff @(posedge hf_clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign div_clk = cnt_q;

  // R5
  msb_carry_chk: assert property (@(posedge hf_clk) disable iff (!rst_n)
    (div_clk[TAPS-1] != $past(div_clk[TAPS-1])) |-> ($past(cnt_q[TAPS-2:0]) == '1));
endmodule

// File: rtl/clksel_startup_timer.sv
`timescale 1ns/1ps
module clksel_startup_timer #(
  parameter int CYCLES = 1024
) (
  input  logic pri_clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          expire;

  assign expire = (cnt_q == LAST);

  always_ff @(posedge pri_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (expire) done_q <= 1'b1;
    end
  end

  assign done = done_q;

  // R7
  ost_count_chk: assert property (@(posedge pri_clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(cnt_q) == LAST));

  // R7
  ost_sticky_chk: assert property (@(posedge pri_clk) disable iff (!rst_n)
    done_q |=> done_q);
endmodule

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
module clksel_regs
  import clksel_pkg::*;
(
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              hf_ready,
  input  logic              lf_ready,
  input  logic              ost_done,
  input  logic              auto_req,
  output logic [REG_W-1:0]  rd_data,
  output logic              use_internal,
  output logic [FREQ_W-1:0] freq_code
);
  logic              scs_q;
  logic [FREQ_W-1:0] freq_q;
  logic [3:0]        raw_st;
  logic [3:0]        st_s;
  logic              unused_wr_bits;

  assign raw_st = {auto_req, ost_done, hf_ready, lf_ready};

  clksel_sync2 #(.W(4)) u_st_sync (
    .clk   (bus_clk),
    .rst_n (rst_n),
    .d     (raw_st),
    .q     (st_s)
  );

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      scs_q  <= 1'b0;
      freq_q <= FREQ_RESET;
    end else if (wr_en) begin
      scs_q  <= wr_data[0];
      freq_q <= wr_data[6:4];
    end
  end

  assign unused_wr_bits = ^{wr_data[7], wr_data[3:1]};

  assign rd_data      = {1'b0, freq_q, st_s[2], st_s[1], st_s[0], scs_q};
  assign use_internal = scs_q | st_s[3];
  assign freq_code    = freq_q;

  // R4
  scs_hold_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !wr_en |=> $stable(scs_q));
endmodule

// File: rtl/clksel_gf_mux.sv
`timescale 1ns/1ps
module clksel_gf_mux #(
  parameter int N      = 9,
  parameter int RST_IX = 0
) (
  input  logic         bus_clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_clk,
  input  logic [N-1:0] tgt_oh,
  output logic         sys_clk
);
  localparam logic [N-1:0] RST_OH = N'(1) << RST_IX;

  logic [N-1:0] sel_q;
  logic [N-1:0] en_q;
  logic [N-1:0] en_seen;
  logic         settled;
  logic         busy;

  clksel_sync2 #(.W(N)) u_back_sync (
    .clk   (bus_clk),
    .rst_n (rst_n),
    .d     (en_q),
    .q     (en_seen)
  );

  assign settled = (en_seen == sel_q);
  assign busy    = !settled;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= RST_OH;
    else if (settled) sel_q <= tgt_oh;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam logic [N-1:0] SELF = N'(1) << i;
    logic [1:0] pipe_q;
    logic       others_on;
    logic       req;

    assign others_on = |(en_q & ~SELF);
    assign req       = sel_q[i] & ~others_on;

    always_ff @(negedge src_clk[i] or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[0], req};
    end

    assign en_q[i] = pipe_q[1];
  end

  assign sys_clk = |(src_clk & en_q);

  // R9
  gate_onehot_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $onehot0(en_q));

  // R9
  sel_hold_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    busy |=> $stable(sel_q));
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
  import clksel_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              pri_clk,
  input  logic              hf_clk,
  input  logic              lf_clk,
  input  logic              hf_ready,
  input  logic              lf_ready,
  input  logic              auto_req,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              sys_clk
);
  logic [POST_TAPS-1:0] taps;
  logic                 ost_done;
  logic                 use_int;
  logic [FREQ_W-1:0]    freq;
  src_vec_t             srcs;
  src_vec_t             tgt;

  clksel_postscaler #(.TAPS(POST_TAPS)) u_post (
    .hf_clk  (hf_clk),
    .rst_n   (rst_n),
    .div_clk (taps)
  );

  clksel_startup_timer #(.CYCLES(OST_CYCLES)) u_ost (
    .pri_clk (pri_clk),
    .rst_n   (rst_n),
    .done    (ost_done)
  );

  clksel_regs u_regs (
    .bus_clk      (bus_clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .hf_ready     (hf_ready),
    .lf_ready     (lf_ready),
    .ost_done     (ost_done),
    .auto_req     (auto_req),
    .rd_data      (rd_data),
    .use_internal (use_int),
    .freq_code    (freq)
  );

  assign srcs[SRC_PRI] = pri_clk;
  assign srcs[SRC_LF]  = lf_clk;
  assign srcs[SRC_HF]  = hf_clk;
  for (genvar c = 1; c <= POST_TAPS; c++) begin : g_tap
    assign srcs[c + 1] = taps[tap_of_code(c)];
  end

  assign tgt = src_onehot(use_int, freq);

  clksel_gf_mux #(.N(NUM_SRC), .RST_IX(SRC_PRI)) u_mux (
    .bus_clk (bus_clk),
    .rst_n   (rst_n),
    .src_clk (srcs),
    .tgt_oh  (tgt),
    .sys_clk (sys_clk)
  );
endmodule

// File: tb/sysclk_switch_bench.sv
`timescale 1ns/1ps
module sysclk_switch_bench;
  logic       bus_clk = 1'b0;
  logic       pri_clk = 1'b0;
  logic       hf_clk  = 1'b0;
  logic       lf_clk  = 1'b0;
  logic       rst_n   = 1'b0;
  logic       hf_ready = 1'b0;
  logic       lf_ready = 1'b0;
  logic       auto_req = 1'b0;
  logic       wr_en    = 1'b0;
  logic [7:0] wr_data  = 8'h00;
  logic [7:0] rd_data;
  logic       sys_clk;

  int vectors = 0;
  int fails   = 0;
  int glitches = 0;
  realtime t_rise = 0.0;
  realtime t_fall = 0.0;

  localparam real PRI_PER = 14.0;
  localparam real HF_PER  = 10.0;
  localparam real LF_PER  = 262.0;

  always #2 bus_clk = ~bus_clk;
  initial begin #1.3; forever #7   pri_clk = ~pri_clk; end
  initial begin #0.7; forever #5   hf_clk  = ~hf_clk;  end
  initial begin #2.9; forever #131 lf_clk  = ~lf_clk;  end

  sysclk_switch u_sysclk_switch (
    .bus_clk  (bus_clk),
    .rst_n    (rst_n),
    .pri_clk  (pri_clk),
    .hf_clk   (hf_clk),
    .lf_clk   (lf_clk),
    .hf_ready (hf_ready),
    .lf_ready (lf_ready),
    .auto_req (auto_req),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .sys_clk  (sys_clk)
  );

  // R9: runt-phase monitor, shortest legal phase is 5 ns
  always @(posedge sys_clk) begin
    if (t_fall > 0.0 && ($realtime - t_fall) < 4.5) glitches++;
    t_rise = $realtime;
  end
  always @(negedge sys_clk) begin
    if (t_rise > 0.0 && ($realtime - t_rise) < 4.5) glitches++;
    t_fall = $realtime;
  end

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_per(input string req, input real act, input real exp);
    vectors++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      fails++;
      $display("FAIL %s: actual period %f expected %f", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge bus_clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (1500) @(negedge bus_clk);
  endtask

  task automatic measure(output real per);
    realtime t0;
    @(posedge sys_clk);
    t0 = $realtime;
    repeat (4) @(posedge sys_clk);
    per = ($realtime - t0) / 4.0;
  endtask

  function automatic real expect_per(input int code);
    if (code == 0) return LF_PER;
    if (code == 7) return HF_PER;
    return HF_PER * real'(1 << (7 - code));
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual still running expected finished");
    finish_run();
  end

  initial begin
    real per;
    #20;
    rst_n = 1'b1;
    @(negedge bus_clk);
    check8("R1 reset value", rd_data, 8'h60);

    repeat (100) @(negedge bus_clk);
    check8("R7 timer clear early", rd_data & 8'h08, 8'h00);
    measure(per);
    check_per("R1 R6 primary after reset", per, PRI_PER);

    // timer expires near 14351 ns
    repeat (3000) @(negedge bus_clk);
    check8("R7 timer clear before 1024 edges", rd_data & 8'h08, 8'h00);
    repeat (750) @(negedge bus_clk);
    check8("R7 timer set after 1024 edges", rd_data & 8'h08, 8'h08);

    hf_ready = 1'b1;
    repeat (3) @(negedge bus_clk);
    check8("R8 fast stable bit", rd_data & 8'h06, 8'h04);
    lf_ready = 1'b1;
    repeat (3) @(negedge bus_clk);
    check8("R8 slow stable bit", rd_data & 8'h06, 8'h06);
    hf_ready = 1'b0;
    repeat (3) @(negedge bus_clk);
    check8("R8 fast stable drops", rd_data & 8'h06, 8'h02);
    hf_ready = 1'b1;
    lf_ready = 1'b0;
    repeat (3) @(negedge bus_clk);

    // R3: bits 7 and 3:1 written high, but bit1 status is low
    write_reg(8'h8E);
    repeat (2) @(negedge bus_clk);
    check8("R3 write ignores bits 7 3:1", rd_data, 8'h0C);
    lf_ready = 1'b1;
    repeat (3) @(negedge bus_clk);
    check8("R7 timer stays set", rd_data & 8'h08, 8'h08);

    // R2 R5: sweep every frequency code on the internal block
    for (int code = 0; code < 8; code++) begin
      write_reg({1'b0, 3'(code), 4'b0001});
      settle();
      check8("R2 select and code readback", rd_data, {1'b0, 3'(code), 4'hF});
      measure(per);
      check_per("R5 internal rate for code", per, expect_per(code));
    end

    write_reg(8'h60);
    settle();
    measure(per);
    check_per("R6 primary with select 0", per, PRI_PER);

    auto_req = 1'b1;
    settle();
    measure(per);
    check_per("R4 auto switch to internal divide by 2", per, 20.0);
    check8("R4 select bit untouched", rd_data & 8'h01, 8'h00);

    write_reg(8'h70);
    settle();
    measure(per);
    check_per("R4 auto switch follows code 111", per, HF_PER);
    check8("R4 select bit stays 0", rd_data, 8'h7E);

    auto_req = 1'b0;
    settle();
    measure(per);
    check_per("R6 back to primary", per, PRI_PER);

    vectors++;
    if (glitches != 0) begin
      fails++;
      $display("FAIL R9 runt phases: actual %0d expected 0", glitches);
    end

    finish_run();
  end
endmodule